// File: doc/BRIEF.md
# Power-of-Two Scaled FP4 Quantize-Dequantize Unit

This unit takes one FP32 element together with an 8-bit power-of-two block scale. The scale code `c` stands for the value 2^(c−127). The unit divides the element's magnitude by the scale and rounds the quotient onto the eight-entry E2M1 magnitude set {0, 0.5, 1, 1.5, 2, 3, 4, 6}. It then rebuilds an FP32 result equal to the input sign times the chosen magnitude times the scale. Because the scale is a pure power of two, both the division and the rebuild reduce to exponent arithmetic. No divider and no multiplier are needed. The 4-bit E2M1 code and the FP32 result are registered together, one cycle after an input strobe.

Seven threshold tests run in parallel on every element, with no data-dependent control flow. A priority chain then turns their results into the codebook index. A separate combinational path forms a scale code from any FP32 value by taking its exponent field. This lets a caller derive the block scale from, for example, a block maximum.

Top module: `fp4_qdq`

## Requirements
- R1: While `rstN` is low, `outValid`, `outCode` and `outValue` are all zero.
- R2: A sample presented with `inValid` high appears on `outCode`/`outValue` with `outValid` high after exactly one rising clock edge. When `inValid` is low, `outValid` drops at the next edge and `outCode`/`outValue` keep their previous values.
- R3: With y = |element| / 2^(inScale−127), the index in `outCode[2:0]` is the number of the decision points 0.25, 0.75, 1.25, 1.75, 2.5, 3.5, 5.0 that y strictly exceeds. Index 0..7 selects the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4, 6 in that order. A y lying exactly on a decision point takes the lower index.
- R4: Any y above 5.0, however large, gives index 7 (magnitude 6).
- R5: For `inScale` from 2 to 252, `outValue[30:0]` is the exact FP32 magnitude of codebook value × 2^(inScale−127). Index 0 gives all-zero magnitude bits.
- R6: `outCode[3]` and `outValue[31]` both equal the element's sign bit. This also holds when the result magnitude is zero.
- R7: `snapCode` equals bits 30:23 of `snapSrc` at all times, with no clock involved.
- R8: A subnormal element (exponent field zero) is quantized by its true value 0.m × 2^−126. A zero element gives index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Element and scale are valid this cycle |
| inElem | input | 32 | FP32 element to quantize |
| inScale | input | 8 | Power-of-two scale code, value 2^(code−127) |
| snapSrc | input | 32 | FP32 value whose exponent forms a scale code |
| outValid | output | 1 | Registered result is fresh |
| outCode | output | 4 | E2M1 code: bit 3 sign, bits 2:0 magnitude index |
| outValue | output | 32 | Dequantized FP32 result |
| snapCode | output | 8 | Scale code snapped from `snapSrc` |

## Verification
The assertions assume that every strobed scale code lies between 2 and 252. Within that range each rebuilt result is a normal, finite FP32 number, and the bound is itself checked as an assertion. They also assume the element is never NaN or infinity, and they say nothing about results for such inputs. The random stimulus draws the scale code only from the legal range. It draws the element exponent from a narrow window around the scale, or sets it to zero for subnormals, and it keeps the exponent field below 255. The directed cases place elements exactly on each decision point and one unit in the last place above it, where the strict-versus-inclusive choice is visible.

// File: rtl/fp4_qdq_pkg.sv
package fp4_qdq_pkg;
  localparam int FP_W      = 32;
  localparam int EXP_W     = 8;
  localparam int MAN_W     = 23;
  localparam int SIG_W     = MAN_W + 1;
  localparam int CODE_W    = 4;
  localparam int IDX_W     = CODE_W - 1;
  localparam int NUM_BOUND = (1 << IDX_W) - 1;
  localparam int Q_FRAC    = 2;                     // quarter resolution of y
  localparam int YQ_W      = 6;                     // {floor(4y), sticky}
  localparam int SAT_D     = YQ_W - 1 - Q_FRAC;     // exponent gap giving y >= 8
  localparam int SH_MID    = MAN_W - Q_FRAC;
  localparam int SH_W      = $clog2(SIG_W);
  localparam int SCALE_MIN = 2;
  localparam int SCALE_MAX = (1 << EXP_W) - 4;

  typedef struct packed {
    logic load;
  } qdqStrobe_t;

  // codebook magnitude times four
  function automatic int cbQuarter(int i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 12;
      6: return 16;
      default: return 24;
    endcase
  endfunction

  // midpoint between entries i and i+1, in eighths (matches {4y, sticky})
  function automatic logic [YQ_W-1:0] boundQ(int i);
    return YQ_W'(cbQuarter(i) + cbQuarter(i + 1));
  endfunction
endpackage

// File: rtl/fp4_qdq_ctrl.sv
module fp4_qdq_ctrl
  import fp4_qdq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output qdqStrobe_t strobe,
  output logic       outValid
);
  always_comb strobe.load = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (outValid == $past(inValid))); // R2
endmodule

// File: rtl/fp4_qdq_dp.sv
module fp4_qdq_dp
  import fp4_qdq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  qdqStrobe_t        strobe,
  input  logic [FP_W-1:0]   inElem,
  input  logic [EXP_W-1:0]  inScale,
  input  logic [FP_W-1:0]   snapSrc,
  output logic [CODE_W-1:0] outCode,
  output logic [FP_W-1:0]   outValue,
  output logic [EXP_W-1:0]  snapCode
);
  localparam logic signed [EXP_W+1:0] D_HI = SAT_D;
  localparam logic signed [EXP_W+1:0] D_LO = -SAT_D;

  logic                     sgn;
  logic [EXP_W-1:0]         ex;
  logic                     hidden;
  logic [EXP_W-1:0]         eEff;
  logic [SIG_W-1:0]         sig;
  logic signed [EXP_W+1:0]  diff;
  logic [SH_W-1:0]          shAmt;
  logic [SIG_W-1:0]         shifted;
  logic                     sticky;
  logic [YQ_W-1:0]          yq;
  logic [NUM_BOUND-1:0]     leVec;
  logic [IDX_W-1:0]         idx;
  logic [1:0]               kPlus1;
  logic                     manTop;
  logic [EXP_W-1:0]         resExp;
  logic [FP_W-1:0]          resVal;

  // y = |x| / scale brought to fixed point with two fraction bits plus sticky
  always_comb begin
    sgn     = inElem[FP_W-1];
    ex      = inElem[FP_W-2 -: EXP_W];
    hidden  = |ex;
    eEff    = hidden ? ex : EXP_W'(1);
    sig     = {hidden, inElem[MAN_W-1:0]};
    diff    = $signed({2'b00, eEff}) - $signed({2'b00, inScale});
    shAmt   = SH_W'(SH_MID - int'(diff));
    shifted = sig >> shAmt;
    sticky  = ((shifted << shAmt) != sig);
    if (diff >= D_HI)      yq = '1;
    else if (diff <= D_LO) yq = {{(YQ_W-1){1'b0}}, |sig};
    else                   yq = {shifted[YQ_W-2:0], sticky};
  end

  // seven comparators, all evaluated every cycle
  for (genvar g = 0; g < NUM_BOUND; g++) begin : gBound
    assign leVec[g] = (yq <= boundQ(g));
  end

  // priority chain: lowest boundary that holds wins
  always_comb begin
    idx = IDX_W'(NUM_BOUND);
    for (int i = NUM_BOUND - 1; i >= 0; i--)
      if (leVec[i]) idx = IDX_W'(i);
  end

  // rebuild: exponent offset (plus one) and leading mantissa bit per entry
  always_comb begin
    case (idx)
      3'd1:    begin kPlus1 = 2'd0; manTop = 1'b0; end
      3'd2:    begin kPlus1 = 2'd1; manTop = 1'b0; end
      3'd3:    begin kPlus1 = 2'd1; manTop = 1'b1; end
      3'd4:    begin kPlus1 = 2'd2; manTop = 1'b0; end
      3'd5:    begin kPlus1 = 2'd2; manTop = 1'b1; end
      3'd6:    begin kPlus1 = 2'd3; manTop = 1'b0; end
      3'd7:    begin kPlus1 = 2'd3; manTop = 1'b1; end
      default: begin kPlus1 = 2'd0; manTop = 1'b0; end
    endcase
    resExp = inScale + EXP_W'(kPlus1) - EXP_W'(1);
    if (idx == '0) resVal = {sgn, {(FP_W-1){1'b0}}};
    else           resVal = {sgn, resExp, manTop, {(MAN_W-1){1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCode  <= '0;
      outValue <= '0;
    end else if (strobe.load) begin
      outCode  <= {sgn, idx};
      outValue <= resVal;
    end
  end

  assign snapCode = snapSrc[FP_W-2 -: EXP_W];

  AST_SCALE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rstN && strobe.load |-> (inScale >= EXP_W'(SCALE_MIN)) && (inScale <= EXP_W'(SCALE_MAX))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !strobe.load |=> $stable(outCode) && $stable(outValue)); // R2
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    rstN && strobe.load |=> (outCode[CODE_W-1] == $past(inElem[FP_W-1])) && (outValue[FP_W-1] == outCode[CODE_W-1])); // R6
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    rstN && strobe.load && ({2'b00, inElem[FP_W-2 -: EXP_W]} >= {2'b00, inScale} + 10'(SAT_D))
    |=> outCode[IDX_W-1:0] == IDX_W'(NUM_BOUND)); // R4
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rstN)
    rstN && strobe.load && (inElem[FP_W-2:0] == '0) |=> (outCode[IDX_W-1:0] == '0) && (outValue[FP_W-2:0] == '0)); // R8
endmodule

// File: rtl/fp4_qdq.sv
module fp4_qdq
  import fp4_qdq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FP_W-1:0]   inElem,
  input  logic [EXP_W-1:0]  inScale,
  input  logic [FP_W-1:0]   snapSrc,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode,
  output logic [FP_W-1:0]   outValue,
  output logic [EXP_W-1:0]  snapCode
);
  qdqStrobe_t strobe;

  fp4_qdq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fp4_qdq_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inElem   (inElem),
    .inScale  (inScale),
    .snapSrc  (snapSrc),
    .outCode  (outCode),
    .outValue (outValue),
    .snapCode (snapCode)
  );
endmodule

// File: tb/sim_fp4_qdq.sv
`timescale 1ns/1ps
module sim_fp4_qdq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inElem = '0;
  logic [7:0]  inScale = 8'd127;
  logic [31:0] snapSrc = '0;
  logic        outValid;
  logic [3:0]  outCode;
  logic [31:0] outValue;
  logic [7:0]  snapCode;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fp4_qdq u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inElem(inElem), .inScale(inScale),
    .snapSrc(snapSrc), .outValid(outValid), .outCode(outCode), .outValue(outValue),
    .snapCode(snapCode)
  );

  function automatic int cb4(int i);
    int t[8] = '{0, 2, 4, 6, 8, 12, 16, 24};
    return t[i];
  endfunction

  // FP32 bits of n * 2^eo, n > 0
  function automatic logic [31:0] fpFromInt(longint unsigned n, int eo);
    int p = 0;
    longint unsigned frac;
    for (int b = 0; b < 64; b++) if (n[b]) p = b;
    frac = n - (64'd1 << p);
    if (p <= 23) frac = frac << (23 - p);
    else         frac = frac >> (p - 23);
    return {1'b0, 8'(eo + p + 127), frac[22:0]};
  endfunction

  // is |x| / 2^(c-127) <= t/4 ?
  function automatic bit leQuarter(logic [31:0] x, int c, int t);
    int e = int'(x[30:23]);
    longint unsigned sig = {40'd0, (e != 0), x[22:0]};
    int sh;
    if (e == 0) e = 1;
    sh = e - c - 21;
    if (sh >= 0) return (sh > 30) ? 1'b0 : ((sig << sh) <= longint'(t));
    if (-sh > 30) return 1'b1;
    return sig <= (longint'(t) << (-sh));
  endfunction

  function automatic int expIdx(logic [31:0] x, int c);
    for (int i = 0; i < 7; i++)
      if (leQuarter(x, c, (cb4(i) + cb4(i + 1)) / 2)) return i;
    return 7;
  endfunction

  function automatic logic [31:0] expVal(logic [31:0] x, int c);
    int i = expIdx(x, c);
    logic [31:0] v = (i == 0) ? 32'd0 : fpFromInt(longint'(cb4(i)), c - 129);
    v[31] = x[31];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runOne(logic [31:0] x, int c, string req);
    inElem = x; inScale = 8'(c); inValid = 1'b1;
    @(negedge clk);
    chk({req, " valid"}, {31'd0, outValid}, 32'd1);
    chk({req, " code"}, {28'd0, outCode}, {28'd0, x[31], 3'(expIdx(x, c))});
    chk({req, " value"}, outValue, expVal(x, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keepCode, keepVal, x;
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R1 valid", {31'd0, outValid}, 32'd0);
    chk("R1 code", {28'd0, outCode}, 32'd0);
    chk("R1 value", outValue, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: exact decision points go low, one ulp above goes high
    for (int c = 100; c <= 140; c += 40) begin
      for (int i = 0; i < 7; i++) begin
        x = fpFromInt(longint'((cb4(i) + cb4(i + 1)) / 2), c - 129);
        runOne(x, c, "R3 tie");
        chk("R3 tie idx", {29'd0, outCode[2:0]}, 32'(i));
        runOne(x + 32'd1, c, "R3 above");
        chk("R3 above idx", {29'd0, outCode[2:0]}, 32'(i + 1));
      end
    end
    // R5: codebook values times scale reproduce themselves
    for (int i = 1; i < 8; i++) begin
      x = fpFromInt(longint'(cb4(i)), 60 - 129);
      runOne(x, 60, "R5 exact");
      chk("R5 exact value", outValue, x);
    end
    // R4: saturation
    runOne(32'h7149F2CA, 127, "R4 huge");
    chk("R4 huge value", outValue, 32'h40C00000);
    runOne(32'hC0B00000, 127, "R4 5.5neg");
    chk("R4 5.5neg code", {28'd0, outCode}, 32'hF);
    // R6: signed zero
    runOne(32'hBE000000, 127, "R6 negsmall");
    chk("R6 negzero", outValue, 32'h80000000);
    chk("R6 code", {28'd0, outCode}, 32'h8);
    // R8: zero and subnormals
    runOne(32'h00000000, 127, "R8 zero");
    runOne(32'h00400000, 2, "R8 sub tie");
    runOne(32'h00600000, 2, "R8 sub mid");
    chk("R8 sub mid value", outValue, 32'h00800000);

    // R2: idle keeps outputs, drops valid
    keepCode = {28'd0, outCode}; keepVal = outValue;
    inValid = 1'b0; inElem = 32'h40400000; inScale = 8'd120;
    @(negedge clk);
    chk("R2 idle valid", {31'd0, outValid}, 32'd0);
    chk("R2 idle code", {28'd0, outCode}, keepCode);
    chk("R2 idle value", outValue, keepVal);

    // R7: scale snap
    for (int k = 0; k < 20; k++) begin
      snapSrc = $urandom;
      #1;
      chk("R7 snap", {24'd0, snapCode}, {24'd0, snapSrc[30:23]});
    end
    @(negedge clk);

    // random mix (R3 R4 R5 R6 R8)
    for (int k = 0; k < 600; k++) begin
      int c = 2 + int'($urandom % 251);
      int e = c - 5 + int'($urandom % 10);
      if (e < 1) e = 1;
      if (e > 254) e = 254;
      if ($urandom % 10 == 0) e = 0;
      x = {1'($urandom), 8'(e), 23'($urandom)};
      runOne(x, c, "R3 rand");
    end
    inValid = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule